// File: doc/BRIEF.md
# Self-Synchronizing Descrambler Error Monitor

This block watches a serial test stream and estimates how many line bits arrived corrupted. The far end scrambles a constant all-zero payload with a linear feedback shift register. The line therefore carries the raw pseudo-random sequence. The receiver holds a shift register that always loads the received line bit and never feeds back its own result. Because of that, it lines up with the sender after as many bits as it has stages, with no acquisition phase. Its descrambled output should stay at zero, and every nonzero output is counted as an error event.

A single corrupted line bit passes through the register and shows up once for each nonzero polynomial term: once directly, and once at every tap lag. The block therefore keeps two counts. The raw count records every error event. The estimate divides the raw count by the polynomial weight, which gives the number of corrupted line bits. A matching scrambler module comes with the block so that a test source can produce the line stream. The polynomial, the register length and the counter width are parameters. The default polynomial is x^11 + x^9 + 1, which has weight 3.

Top module: `ssd_err_monitor`

## Requirements
- R1: While reset is held, descr_bit, err_strobe, raw_count and est_count are all zero.
- R2: After the register has filled, descr_bit is registered at the edge that samples line_bit. Its value is line_bit XOR the line bits received at each tap lag (9 and 11 bits earlier by default). On an error-free scrambled stream it is 0.
- R3: err_strobe stays low for the first ORDER enabled bits after reset. From then on, with an error-free stream, it stays low whatever the register held before. No acquisition step is needed.
- R4: One corrupted line bit, isolated by more than ORDER bits from any other, raises err_strobe at exactly these points: the enabled bit where it arrives, and the enabled bits at each tap lag after it. That is WEIGHT strobes in total (3 by default). Whenever err_strobe is high, descr_bit is also high.
- R5: raw_count increments by one at the same edge as each err_strobe. It never changes otherwise, and it stops at 2^CNT_W-1.
- R6: est_count always equals floor(raw_count / WEIGHT), where WEIGHT is one plus the number of set bits in the tap mask. It therefore steps by exactly one for each isolated line error.
- R7: When raw_count reaches its maximum, est_count freezes with it. If the saturating increment and an estimate step fall in the same cycle, both take effect.
- R8: When en is low, line_bit is ignored. The register does not shift, err_strobe is 0 and both counts hold. Pending tap-lag echoes resume when en returns.
- R9: The companion scrambler, fed a zero data bit, sends the XOR of its own past outputs at the tap lags. A descrambler with the same taps recovers zeros from that stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Bit enable; line_bit is taken only when high |
| line_bit | input | 1 | Received serial line bit |
| descr_bit | output | 1 | Registered descrambler output |
| err_strobe | output | 1 | One-cycle pulse per nonzero descrambler output after fill |
| raw_count | output | CNT_W | Saturating count of error events |
| est_count | output | CNT_W | Estimated corrupted line bits, raw_count divided by WEIGHT |

## Verification
Two things can fall in the same cycle: the raw counter reaching saturation and the estimate rolling over to its next value. With a 6-bit counter and weight 3, the 21st isolated error pushes raw_count to 63 on its last echo, and on that same edge est_count must step to 21. Later errors must move neither count. The bench also places an enable pause between a line error and its delayed echoes, so that the echo timing has to survive the hold. The expected strobe positions come from the tap lags in the bench's own bit count.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

    // Number of nonzero polynomial terms: set tap bits plus the x^0 term.
    function automatic int unsigned term_count(input logic [31:0] taps);
        int unsigned n;
        n = 1;
        for (int i = 0; i < 32; i++) begin
            if (taps[i]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/ssd_scrambler.sv
// Test-source scrambler: the feedback dual of the descrambler.
// TAPS bit k-1 selects the output sent k bits earlier.
module ssd_scrambler #(
    parameter int unsigned       ORDER = 11,
    parameter logic [ORDER-1:0]  TAPS  = 11'h500,
    parameter logic [ORDER-1:0]  SEED  = 11'h5A3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic data_bit,
    output logic line_bit
);

    typedef struct packed {
        logic [ORDER-1:0] hist;
    } scr_state_t;

    scr_state_t s_d, s_q;

    always_comb begin
        line_bit = data_bit ^ (^(s_q.hist & TAPS));
        s_d = s_q;
        if (en) begin
            s_d.hist = {s_q.hist[ORDER-2:0], line_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{hist: SEED};
        else        s_q <= s_d;
    end

endmodule

// File: rtl/ssd_descrambler.sv
// Receive register that always loads the line bit; the fill counter masks
// error reports until every stage holds a received bit.
module ssd_descrambler #(
    parameter int unsigned       ORDER = 11,
    parameter logic [ORDER-1:0]  TAPS  = 11'h500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic line_bit,
    output logic err_now,
    output logic descr_bit,
    output logic err_strobe
);

    localparam int unsigned FILL_W = $clog2(ORDER + 1);

    typedef struct packed {
        logic [ORDER-1:0]  hist;
        logic [FILL_W-1:0] fill;
        logic              descr;
        logic              strobe;
    } dsc_state_t;

    dsc_state_t s_d, s_q;
    logic       filled;
    logic       mix;

    always_comb begin
        mix     = line_bit ^ (^(s_q.hist & TAPS));
        filled  = (s_q.fill == FILL_W'(ORDER));
        err_now = en & filled & mix;

        s_d        = s_q;
        s_d.strobe = 1'b0;
        if (en) begin
            s_d.hist   = {s_q.hist[ORDER-2:0], line_bit};
            s_d.descr  = mix;
            s_d.strobe = err_now;
            if (!filled) s_d.fill = s_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign descr_bit  = s_q.descr;
    assign err_strobe = s_q.strobe;

endmodule

// File: rtl/ssd_err_tally.sv
// Saturating raw event counter plus a residue counter that divides by the
// polynomial weight without a divider.
module ssd_err_tally #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned WEIGHT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    output logic [CNT_W-1:0] raw_count,
    output logic [CNT_W-1:0] est_count
);

    localparam int unsigned      RES_W   = (WEIGHT > 1) ? $clog2(WEIGHT) : 1;
    localparam logic [CNT_W-1:0] RAW_MAX = {CNT_W{1'b1}};
    localparam logic [RES_W-1:0] RES_TOP = RES_W'(WEIGHT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] raw;
        logic [CNT_W-1:0] est;
        logic [RES_W-1:0] res;
    } tally_state_t;

    tally_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hit && (s_q.raw != RAW_MAX)) begin
            s_d.raw = s_q.raw + 1'b1;
            if (s_q.res == RES_TOP) begin
                s_d.res = '0;
                s_d.est = s_q.est + 1'b1;
            end else begin
                s_d.res = s_q.res + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign raw_count = s_q.raw;
    assign est_count = s_q.est;

endmodule

// File: rtl/ssd_err_monitor.sv
module ssd_err_monitor #(
    parameter int unsigned       ORDER = 11,
    parameter logic [ORDER-1:0]  TAPS  = 11'h500,
    parameter int unsigned       CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             line_bit,
    output logic             descr_bit,
    output logic             err_strobe,
    output logic [CNT_W-1:0] raw_count,
    output logic [CNT_W-1:0] est_count
);

    localparam int unsigned WEIGHT = ssd_pkg::term_count(32'(TAPS));

    logic err_now;

    ssd_descrambler #(
        .ORDER (ORDER),
        .TAPS  (TAPS)
    ) dsc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .line_bit   (line_bit),
        .err_now    (err_now),
        .descr_bit  (descr_bit),
        .err_strobe (err_strobe)
    );

    ssd_err_tally #(
        .CNT_W  (CNT_W),
        .WEIGHT (WEIGHT)
    ) tally_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (err_now),
        .raw_count (raw_count),
        .est_count (est_count)
    );

endmodule

// File: rtl/ssd_err_monitor_chk.sv
module ssd_err_monitor_chk #(
    parameter int unsigned       ORDER = 11,
    parameter logic [ORDER-1:0]  TAPS  = 11'h500,
    parameter int unsigned       CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             descr_bit,
    input logic             err_strobe,
    input logic [CNT_W-1:0] raw_count,
    input logic [CNT_W-1:0] est_count
);

    localparam int unsigned      WEIGHT  = ssd_pkg::term_count(32'(TAPS));
    localparam int unsigned      SEEN_W  = $clog2(ORDER + 2);
    localparam logic [CNT_W-1:0] RAW_MAX = {CNT_W{1'b1}};

    logic [SEEN_W-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else if (en && (seen_q <= SEEN_W'(ORDER))) seen_q <= seen_q + 1'b1;
    end

    p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe |-> (seen_q > SEEN_W'(ORDER)));

    p_strobe_descr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe |-> descr_bit);

    p_raw_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe |-> (raw_count == $past(raw_count) + 1'b1) || (raw_count == RAW_MAX));

    p_raw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !err_strobe |-> $stable(raw_count));

    p_est_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (est_count == $past(est_count)) || (est_count == $past(est_count) + 1'b1));

    p_est_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (64'(est_count) * 64'(WEIGHT)) <= 64'(raw_count));

    p_sat_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(raw_count) == RAW_MAX) |-> (raw_count == RAW_MAX) && $stable(est_count));

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !err_strobe && $stable(raw_count) && $stable(est_count));

endmodule

bind ssd_err_monitor ssd_err_monitor_chk #(
    .ORDER (ORDER),
    .TAPS  (TAPS),
    .CNT_W (CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .descr_bit  (descr_bit),
    .err_strobe (err_strobe),
    .raw_count  (raw_count),
    .est_count  (est_count)
);

// File: tb/ssd_err_monitor_tb_top.sv
`timescale 1ns/1ps
module ssd_err_monitor_tb_top;

    localparam int unsigned      ORDER = 11;
    localparam logic [ORDER-1:0] TAPS  = 11'h500;
    localparam int unsigned      CNT_W = 6;
    localparam int unsigned      W     = 3;
    localparam int               RMAX  = 63;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             scr_rst_n = 1'b0;
    logic             en = 1'b0;
    logic             inj = 1'b0;
    logic             scr_line;
    logic             line_bit;
    logic             descr_bit;
    logic             err_strobe;
    logic [CNT_W-1:0] raw_count;
    logic [CNT_W-1:0] est_count;

    int errors = 0;
    int checks = 0;
    int bitnum = 0;
    int lag    = 1000;
    int raw_exp = 0;

    always #5 clk = ~clk;

    assign line_bit = scr_line ^ inj;

    ssd_scrambler #(.ORDER(ORDER), .TAPS(TAPS), .SEED(11'h5A3)) scr_i (
        .clk(clk), .rst_n(scr_rst_n), .en(en), .data_bit(1'b0), .line_bit(scr_line)
    );

    ssd_err_monitor #(.ORDER(ORDER), .TAPS(TAPS), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .line_bit(line_bit),
        .descr_bit(descr_bit), .err_strobe(err_strobe),
        .raw_count(raw_count), .est_count(est_count)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // One bit time: drive at the falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic i_en, input logic i_inj, input string tag);
        logic exp_err;
        @(negedge clk);
        en  = i_en;
        inj = i_inj;
        @(posedge clk);
        #1;
        exp_err = 1'b0;
        if (i_en) begin
            bitnum++;
            if (i_inj) lag = 0;
            else if (lag < 1000) lag++;
            if (bitnum > ORDER) begin
                if (lag == 0) exp_err = 1'b1;
                else if (lag <= ORDER) exp_err = TAPS[lag-1];
                check("R2", "descr_bit", int'(descr_bit), int'(exp_err));
            end
            if (exp_err && raw_exp < RMAX) raw_exp++;
        end
        check(tag, "err_strobe", int'(err_strobe), int'(exp_err));
        check(tag, "raw_count", int'(raw_count), raw_exp);
        check("R6", "est_count", int'(est_count), raw_exp / W);
        inj = 1'b0;
    endtask

    task automatic one_error(input int gap, input string tag);
        step(1'b1, 1'b1, tag);
        for (int i = 0; i < gap; i++) step(1'b1, 1'b0, tag);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", "descr_bit", int'(descr_bit), 0);
        check("R1", "err_strobe", int'(err_strobe), 0);
        check("R1", "raw_count", int'(raw_count), 0);
        check("R1", "est_count", int'(est_count), 0);
        @(negedge clk);
        rst_n = 1'b1;
        scr_rst_n = 1'b1;

        // R3, R9: clean stream from a cold register; fill masks the mismatch
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, "R3");

        // R4: isolated errors, each producing WEIGHT strobes
        for (int k = 1; k <= 5; k++) begin
            one_error(39, "R4");
            check("R4", "raw after error", int'(raw_count), 3 * k);
            check("R6", "est after error", int'(est_count), k);
        end

        // R8: error, then a pause with a toggling line, then its echoes
        one_error(3, "R8");
        for (int i = 0; i < 15; i++) step(1'b0, (i % 2 == 0), "R8");
        for (int i = 0; i < 36; i++) step(1'b1, 1'b0, "R8");
        check("R8", "raw after pause", int'(raw_count), 18);
        check("R8", "est after pause", int'(est_count), 6);

        for (int k = 7; k <= 20; k++) one_error(39, "R5");
        check("R5", "raw before sat", int'(raw_count), 60);

        // R7: saturation and estimate step on the same edge
        one_error(39, "R7");
        check("R7", "raw saturated", int'(raw_count), 63);
        check("R7", "est at saturation", int'(est_count), 21);
        one_error(39, "R7");
        one_error(39, "R7");
        check("R7", "raw held", int'(raw_count), 63);
        check("R7", "est frozen", int'(est_count), 21);

        // R3: reset only the monitor while the source keeps running
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "raw in reset", int'(raw_count), 0);
        @(negedge clk);
        rst_n = 1'b1;
        bitnum = 0;
        lag = 1000;
        raw_exp = 0;
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, "R3");
        check("R3", "raw after resync", int'(raw_count), 0);

        summary();
        $finish;
    end

endmodule